// File: doc/BRIEF.md
# Snooping TLB with Page-Table Line Tracking

This block is a small, fully associative translation buffer. For each entry it keeps the virtual page number, the physical page number and, for every page-table level the walker passed through, the address of the cache line that held the PTE it used. It watches a coherent memory bus. When another agent writes one of those lines, the entry built from it is dropped at once. No fence instruction is needed. Invalidation works per cache line, so an update to one part of a page table removes only the translations that read that part.

When another agent reads a tracked line, the block drives a wired-OR response on the bus that means "shared, no data supplied". The reader then has to take the line as shared and cannot write it silently, so later writes to that line still appear on the bus. Writes that the block's own MMU makes, such as accessed/dirty updates, never cause an invalidation.

A lookup that hits marks its entry busy and records the tag of the instruction that used it. The commit of that tag clears the mark. If a busy entry is invalidated, the block raises a pipeline-flush request. New walks are written to the slots in round-robin order.

Top module: `snoop_tlb`

## Requirements
- R1: After reset no entry is valid. `lk_hit`, `flush_req`, `live_pt` and every bit of `busy_vec` are 0.
- R2: A lookup whose VPN matches a valid entry sets `lk_hit` in the same cycle and returns that entry's PPN on `lk_ppn`. A lookup of a VPN that is not held misses. At most one entry matches.
- R3: A snooped write (`snp_write`=1, `snp_from_mmu`=0) invalidates every entry that recorded the written line. Addresses are compared on bits [ADDR_W-1:LINE_OFS] only; with the default LINE_OFS=6 that is 64-byte lines. A write to another line of the same page-table page leaves the entry valid.
- R4: A snooped write with `snp_from_mmu`=1 never invalidates an entry.
- R5: A snooped read (`snp_write`=0) by another agent of a tracked line sets `live_pt` in the same cycle. `live_pt` stays 0 in each of these cases:
  - a read of an untracked line;
  - any write;
  - a read flagged `snp_from_mmu`.
- R6: A hit with `lk_valid`=1 sets that entry's bit in `busy_vec` from the next cycle and stores `lk_tag`. A `commit_valid` with an equal `commit_tag` clears the bit from the next cycle. A commit with a different tag leaves it set.
- R7: Invalidating an entry whose busy bit is set raises `flush_req` for exactly one cycle, in the cycle after the snoop. Invalidating an entry that is not busy does not raise it.
- R8: A lookup and a snoop write that invalidates the matching entry in the same cycle give a miss.
- R9: Fill line slot i is tracked only when bit i of `fill_lmask` is 1. Bit 0 goes with the `fill_lines` field at bits [ADDR_W-1:0]. A write to an untracked slot's address does not invalidate the entry.
- R10: Fills go to slots 0, 1, …, ENTRIES-1 in order and then wrap. The (ENTRIES+1)-th fill after reset evicts the first one.
- R11: A fill whose tracked line is written by another agent in the same cycle is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_tag | input | TAG_W | Tag of the instruction doing the lookup |
| lk_hit | output | 1 | Lookup hit (same cycle) |
| lk_ppn | output | PPN_W | Physical page number on hit |
| commit_valid | input | 1 | An instruction commits |
| commit_tag | input | TAG_W | Tag of the committing instruction |
| fill_valid | input | 1 | Walker writes a new entry |
| fill_vpn | input | VPN_W | New entry's VPN |
| fill_ppn | input | PPN_W | New entry's PPN |
| fill_lines | input | LEVELS*ADDR_W | PTE addresses, one per level, level 0 in the low field |
| fill_lmask | input | LEVELS | Which line slots are tracked |
| snp_valid | input | 1 | Bus transaction observed |
| snp_write | input | 1 | Observed transaction is a write |
| snp_from_mmu | input | 1 | Transaction issued by this block's own MMU |
| snp_addr | input | ADDR_W | Transaction address |
| live_pt | output | 1 | Wired-OR "shared, no data" response |
| flush_req | output | 1 | Pipeline flush request |
| busy_vec | output | ENTRIES | Busy bit per entry |

## Verification
The hardest case to reach is a busy entry losing its line while other activity happens in the same cycles. This covers two collisions: a lookup and a killing write to the same entry, and a fill whose own line is written as it is installed. The bench reaches each one by setting all the inputs involved on the same falling edge. It then reads the result at the ports: `lk_hit` in that cycle, `flush_req` one cycle later, and a follow-up lookup to show whether the entry survived. For the round-robin check, the bench resets first so that it knows the slot order.

// File: rtl/snoop_tlb.sv
module snoop_tlb #(
  parameter int ENTRIES  = 4,
  parameter int LEVELS   = 2,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int TAG_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     lk_hit,
  output logic [PPN_W-1:0]         lk_ppn,
  input  logic                     commit_valid,
  input  logic [TAG_W-1:0]         commit_tag,
  input  logic                     fill_valid,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic [LEVELS*ADDR_W-1:0] fill_lines,
  input  logic [LEVELS-1:0]        fill_lmask,
  input  logic                     snp_valid,
  input  logic                     snp_write,
  input  logic                     snp_from_mmu,
  input  logic [ADDR_W-1:0]        snp_addr,
  output logic                     live_pt,
  output logic                     flush_req,
  output logic [ENTRIES-1:0]       busy_vec
);
  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam int IDX_W  = ENTRIES > 1 ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, busy_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LEVELS-1:0]  lmask_q[ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES][LEVELS];
  logic [IDX_W-1:0]   ptr_q;
  logic               flush_q;

  logic [LINE_W-1:0]  snp_line;
  logic [ENTRIES-1:0] track, kill, hit_vec;
  logic [LEVELS-1:0]  fill_match;
  logic               other_wr, fill_drop;

  assign snp_line = snp_addr[ADDR_W-1:LINE_OFS];
  assign other_wr = snp_valid & snp_write & ~snp_from_mmu;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [LEVELS-1:0] lvl_match;
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      assign lvl_match[l] = lmask_q[e][l] & (line_q[e][l] == snp_line);
    end
    assign track[e]   = valid_q[e] & (|lvl_match);
    assign kill[e]    = track[e] & other_wr;
    assign hit_vec[e] = lk_valid & valid_q[e] & (vpn_q[e] == lk_vpn) & ~kill[e];
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_fill
    assign fill_match[l] = fill_lmask[l] &
                           (fill_lines[l*ADDR_W+LINE_OFS +: LINE_W] == snp_line);
  end
  assign fill_drop = other_wr & (|fill_match);

  assign live_pt   = snp_valid & ~snp_write & ~snp_from_mmu & (|track);
  assign lk_hit    = |hit_vec;
  assign flush_req = flush_q;
  assign busy_vec  = busy_q;

  always_comb begin
    lk_ppn = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (hit_vec[e]) lk_ppn = lk_ppn | ppn_q[e];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      busy_q  <= '0;
      ptr_q   <= '0;
      flush_q <= 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        vpn_q[e]   <= '0;
        ppn_q[e]   <= '0;
        tag_q[e]   <= '0;
        lmask_q[e] <= '0;
        for (int l = 0; l < LEVELS; l++) line_q[e][l] <= '0;
      end
    end else begin
      flush_q <= |(kill & busy_q);
      for (int e = 0; e < ENTRIES; e++) begin
        if (kill[e]) begin
          valid_q[e] <= 1'b0;
          busy_q[e]  <= 1'b0;
        end else if (hit_vec[e]) begin
          busy_q[e] <= 1'b1;
          tag_q[e]  <= lk_tag;
        end else if (commit_valid && busy_q[e] && tag_q[e] == commit_tag) begin
          busy_q[e] <= 1'b0;
        end
        if (fill_valid && ptr_q == IDX_W'(e)) begin
          valid_q[e] <= ~fill_drop;
          busy_q[e]  <= 1'b0;
          vpn_q[e]   <= fill_vpn;
          ppn_q[e]   <= fill_ppn;
          lmask_q[e] <= fill_lmask;
          for (int l = 0; l < LEVELS; l++)
            line_q[e][l] <= fill_lines[l*ADDR_W+LINE_OFS +: LINE_W];
        end
      end
      if (fill_valid) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r4_own_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_write && snp_from_mmu && !fill_valid) |=> valid_q == $past(valid_q));

  a_r6_busy_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q & ~valid_q) == '0);

  a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(snp_valid && snp_write && !snp_from_mmu));

  a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));
endmodule

// File: tb/test_snoop_tlb.sv
module test_snoop_tlb;
  localparam int ENTRIES = 4, LEVELS = 2, ADDR_W = 32, VPN_W = 20, PPN_W = 20, TAG_W = 4;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0; logic [VPN_W-1:0] lk_vpn = '0; logic [TAG_W-1:0] lk_tag = '0;
  logic lk_hit; logic [PPN_W-1:0] lk_ppn;
  logic commit_valid = 0; logic [TAG_W-1:0] commit_tag = '0;
  logic fill_valid = 0; logic [VPN_W-1:0] fill_vpn = '0; logic [PPN_W-1:0] fill_ppn = '0;
  logic [LEVELS*ADDR_W-1:0] fill_lines = '0; logic [LEVELS-1:0] fill_lmask = '0;
  logic snp_valid = 0, snp_write = 0, snp_from_mmu = 0; logic [ADDR_W-1:0] snp_addr = '0;
  logic live_pt, flush_req; logic [ENTRIES-1:0] busy_vec;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  snoop_tlb i_snoop_tlb (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic fill(logic [19:0] v, logic [19:0] p, logic [31:0] a0, logic [31:0] a1,
                      logic [1:0] m);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_lines = {a1, a0}; fill_lmask = m;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic probe(string req, logic [19:0] v, logic exp_hit, logic [19:0] exp_ppn);
    @(negedge clk); lk_valid = 1; lk_vpn = v; lk_tag = 4'hF; #1;
    chk(req, lk_hit, exp_hit);
    if (exp_hit) chk(req, lk_ppn, exp_ppn);
    @(negedge clk); lk_valid = 0;
    commit_valid = 1; commit_tag = 4'hF;
    @(negedge clk); commit_valid = 0;
  endtask

  task automatic snoop(logic [31:0] a, logic wr, logic mmu);
    @(negedge clk); snp_valid = 1; snp_addr = a; snp_write = wr; snp_from_mmu = mmu;
    @(negedge clk); snp_valid = 0; snp_write = 0; snp_from_mmu = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 hit", lk_hit, 0); chk("R1 flush", flush_req, 0);
    chk("R1 busy", busy_vec, 0); chk("R1 live", live_pt, 0);
    probe("R1 empty miss", 20'h00001, 0, 0);
  endtask

  task automatic t_hit();
    fill(20'h00010, 20'hAAAA0, 32'h1000_0040, 32'h2000_0080, 2'b11);
    probe("R2 hit", 20'h00010, 1, 20'hAAAA0);
    probe("R2 other miss", 20'h00011, 0, 0);
  endtask

  task automatic t_live();
    @(negedge clk); snp_valid = 1; snp_addr = 32'h2000_00BC; #1;
    chk("R5 live tracked read", live_pt, 1);
    snp_addr = 32'h2000_00C0; #1; chk("R5 untracked read", live_pt, 0);
    snp_addr = 32'h2000_0080; snp_from_mmu = 1; #1; chk("R5 mmu read", live_pt, 0);
    snp_from_mmu = 0; snp_write = 1; snp_addr = 32'h3000_0000; #1;
    chk("R5 write no live", live_pt, 0);
    @(negedge clk); snp_valid = 0; snp_write = 0;
  endtask

  task automatic t_granule();
    snoop(32'h1000_0000, 1, 0);
    probe("R3 neighbour line keeps", 20'h00010, 1, 20'hAAAA0);
    snoop(32'h1000_007F, 1, 0);
    probe("R3 tracked line kills", 20'h00010, 0, 0);
  endtask

  task automatic t_own_write();
    fill(20'h00020, 20'hBBBB0, 32'h1000_0100, 32'h2000_0100, 2'b11);
    snoop(32'h1000_0100, 1, 1);
    probe("R4 own write keeps", 20'h00020, 1, 20'hBBBB0);
  endtask

  task automatic t_busy();
    @(negedge clk); lk_valid = 1; lk_vpn = 20'h00020; lk_tag = 4'h5;
    @(negedge clk); lk_valid = 0; chk("R6 busy set", busy_vec != 0, 1);
    commit_valid = 1; commit_tag = 4'h3;
    @(negedge clk); commit_valid = 0; chk("R6 other commit", busy_vec != 0, 1);
    commit_valid = 1; commit_tag = 4'h5;
    @(negedge clk); commit_valid = 0; chk("R6 commit clears", busy_vec, 0);
  endtask

  task automatic t_flush();
    @(negedge clk); lk_valid = 1; lk_vpn = 20'h00020; lk_tag = 4'h7;
    @(negedge clk); lk_valid = 0;
    snp_valid = 1; snp_write = 1; snp_addr = 32'h2000_0104;
    @(negedge clk); snp_valid = 0; snp_write = 0;
    chk("R7 flush raised", flush_req, 1); chk("R7 busy dropped", busy_vec, 0);
    @(negedge clk); chk("R7 flush one cycle", flush_req, 0);
    fill(20'h00030, 20'hCCCC0, 32'h1000_0200, 32'h2000_0200, 2'b11);
    snoop(32'h1000_0200, 1, 0);
    chk("R7 idle kill no flush", flush_req, 0);
  endtask

  task automatic t_collide();
    fill(20'h00040, 20'hDDDD0, 32'h1000_0300, 32'h2000_0300, 2'b11);
    @(negedge clk); lk_valid = 1; lk_vpn = 20'h00040; lk_tag = 4'h2;
    snp_valid = 1; snp_write = 1; snp_addr = 32'h2000_0300; #1;
    chk("R8 same-cycle miss", lk_hit, 0);
    @(negedge clk); lk_valid = 0; snp_valid = 0; snp_write = 0;
    chk("R8 no busy", busy_vec, 0);
  endtask

  task automatic t_mask();
    fill(20'h00050, 20'hEEEE0, 32'h1000_0400, 32'h2000_0400, 2'b01);
    snoop(32'h2000_0400, 1, 0);
    probe("R9 masked slot ignored", 20'h00050, 1, 20'hEEEE0);
    snoop(32'h1000_0400, 1, 0);
    probe("R9 low slot tracked", 20'h00050, 0, 0);
  endtask

  task automatic t_fill_drop();
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h00060; fill_ppn = 20'h11110;
    fill_lines = {32'h2000_0500, 32'h1000_0500}; fill_lmask = 2'b11;
    snp_valid = 1; snp_write = 1; snp_addr = 32'h2000_0510;
    @(negedge clk); fill_valid = 0; snp_valid = 0; snp_write = 0;
    probe("R11 fill dropped", 20'h00060, 0, 0);
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 0; i <= ENTRIES; i++)
      fill(20'h00100 + 20'(i), 20'h50000 + 20'(i), 32'h4000_0000 + 32'(i*64),
           32'h5000_0000 + 32'(i*64), 2'b11);
    probe("R10 oldest evicted", 20'h00100, 0, 0);
    for (int i = 1; i <= ENTRIES; i++)
      probe("R10 newer kept", 20'h00100 + 20'(i), 1, 20'h50000 + 20'(i));
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset(); t_hit(); t_live(); t_granule(); t_own_write(); t_busy();
    t_flush(); t_collide(); t_mask(); t_fill_drop(); t_rr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule